// File: doc/BRIEF.md
# Two-Level Page-Table Refill Walker

This block refills a translation cache without a software trap. When the translation cache misses, the requester presents the missing 20-bit virtual page number, together with a flag saying whether the access was an instruction fetch or a data access. The walker then reads two entries from memory. The first is an entry of the root table, chosen by the upper ten page-number bits. It names the frame that holds one page of 1024 leaf entries. The second is the leaf entry in that page, chosen by the lower ten bits. The walker then writes the virtual-to-physical pair straight into the translation cache.

The requester sees only a busy level and a completion pulse, so no pipeline flush is needed, and unrelated work may continue while a walk is in flight. Memory is reached through one read channel that allows a single outstanding request. A request is a one-cycle strobe with an address. The answer returns with a valid strobe after any number of cycles. An entry whose valid bit is clear ends the walk with a fault pulse that carries the page number, and nothing is written into the cache.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and after it is released with no miss pending, busy, done, fault, memory request and cache write are all low.
- R2: A miss is accepted only when the walker is idle. `miss_valid_i` while busy is ignored: the page number, root base and fetch/data flag captured at acceptance are the ones used for the whole walk and reported at its end.
- R3: In the cycle after acceptance the walker raises `mem_req_o` for one cycle. The address is the root base frame followed by VPN[19:10] followed by two zero bits: {root_base, vpn[19:10], 2'b00}.
- R4: In the cycle after a valid root response, a one-cycle leaf request is issued to {root_pte[31:12], vpn[9:0], 2'b00}.
- R5: Any number of wait cycles before `mem_rsp_valid_i` is tolerated. `mem_req_o` is never high on two consecutive cycles, and a response strobe while no read is outstanding has no effect.
- R6: An entry is valid when bit 0 is 1. In the cycle after a valid leaf response, `tlb_we_o` and `done_o` are high for exactly one cycle. In that cycle `tlb_vpn_o` is the captured page number, `tlb_pfn_o` is leaf_pte[31:12], and `tlb_is_data_o` is the captured flag.
- R7: A root entry with bit 0 clear gives a one-cycle `fault_o` in the next cycle, with `fault_vpn_o` equal to the captured page number. No leaf read is issued, and there is no cache write or done.
- R8: A leaf entry with bit 0 clear gives a one-cycle `fault_o` in the next cycle, with `fault_vpn_o` set, and there is no cache write or done.
- R9: `busy_o` is high from the cycle after acceptance through the cycle of the write or fault pulse, and low in the cycle after that pulse.
- R10: Entry bits 11:1 have no effect on the addresses, the frame number or the fault decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request strobe |
| miss_vpn_i | input | 20 | Missing virtual page number |
| miss_is_data_i | input | 1 | 1 = data access, 0 = instruction fetch |
| root_base_i | input | 20 | Frame number of the root table |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Refill complete pulse |
| fault_o | output | 1 | Invalid entry pulse |
| fault_vpn_o | output | 20 | Page number that faulted |
| mem_req_o | output | 1 | Memory read request strobe |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| tlb_we_o | output | 1 | Translation cache write strobe |
| tlb_vpn_o | output | 20 | Page number written |
| tlb_pfn_o | output | 20 | Frame number written |
| tlb_is_data_o | output | 1 | Instruction/data select for the write |

## Verification
The cycle-by-cycle rules are checked on every clock edge by assertions:
- request strobes last one cycle;
- a wait state holds until its response arrives;
- a new walk never starts from a busy state;
- the captured page number stays stable during a walk;
- a write or fault pulse follows a response whose valid bit has the matching value, and busy then drops.

Only the bench scenarios can show that the data is correct. These cover the exact root and leaf addresses, the frame number and the select flag that are written, the ignored intruding misses and stray responses, and the insensitivity to bits 11:1. The bench sweeps page numbers, base frames and memory latencies, and computes every expected value arithmetically.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RD_ROOT = 3'd1,
    S_WT_ROOT = 3'd2,
    S_RD_LEAF = 3'd3,
    S_WT_LEAF = 3'd4,
    S_FILL    = 3'd5,
    S_FAULT   = 3'd6
  } walk_st_e;
endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     miss_valid_i,
  input  logic     rsp_valid_i,
  input  logic     pte_valid_i,
  output walk_st_e state_o
);
  walk_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (miss_valid_i) state_d = S_RD_ROOT;
      S_RD_ROOT: state_d = S_WT_ROOT;
      S_WT_ROOT: if (rsp_valid_i) state_d = pte_valid_i ? S_RD_LEAF : S_FAULT;
      S_RD_LEAF: state_d = S_WT_LEAF;
      S_WT_LEAF: if (rsp_valid_i) state_d = pte_valid_i ? S_FILL : S_FAULT;
      S_FILL:    state_d = S_IDLE;
      S_FAULT:   state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  restart_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> (state_q != S_RD_ROOT));
  // R5
  root_wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WT_ROOT && !rsp_valid_i) |=> (state_q == S_WT_ROOT));
  // R5
  leaf_wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WT_LEAF && !rsp_valid_i) |=> (state_q == S_WT_LEAF));
endmodule

// File: rtl/ptw_regs.sv
module ptw_regs
  import ptw_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  walk_st_e         state_i,
  input  logic             miss_valid_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             is_data_i,
  input  logic [PFN_W-1:0] base_i,
  input  logic             rsp_valid_i,
  input  logic [PFN_W-1:0] pte_frame_i,
  output logic [VPN_W-1:0] vpn_o,
  output logic             is_data_o,
  output logic [PFN_W-1:0] base_o,
  output logic [PFN_W-1:0] frame_o
);
  logic accept, take_frame;

  assign accept     = (state_i == S_IDLE) && miss_valid_i;
  // one register holds the leaf-page frame, then the final frame
  assign take_frame = rsp_valid_i && (state_i == S_WT_ROOT || state_i == S_WT_LEAF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_o     <= '0;
      is_data_o <= 1'b0;
      base_o    <= '0;
    end else if (accept) begin
      vpn_o     <= vpn_i;
      is_data_o <= is_data_i;
      base_o    <= base_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         frame_o <= '0;
    else if (take_frame) frame_o <= pte_frame_i;
  end

  // R2
  vpn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != S_IDLE) |=> $stable(vpn_o) && $stable(is_data_o));
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int IDX_W    = 10,
  parameter int PFN_W    = 20,
  parameter int ENTRY_LG = 2
) (
  input  walk_st_e                      state_i,
  input  logic [VPN_W-1:0]              vpn_i,
  input  logic [PFN_W-1:0]              base_i,
  input  logic [PFN_W-1:0]              frame_i,
  output logic                          req_o,
  output logic [PFN_W+IDX_W+ENTRY_LG-1:0] addr_o
);
  localparam int ROOT_W = VPN_W - IDX_W;
  localparam int OFF_W  = IDX_W + ENTRY_LG;

  logic [ROOT_W-1:0] root_idx;
  logic [IDX_W-1:0]  leaf_idx;
  logic [OFF_W-1:0]  root_off, leaf_off;

  assign root_idx = vpn_i[VPN_W-1:IDX_W];
  assign leaf_idx = vpn_i[IDX_W-1:0];
  assign root_off = OFF_W'(root_idx) << ENTRY_LG;
  assign leaf_off = OFF_W'(leaf_idx) << ENTRY_LG;

  assign req_o = (state_i == S_RD_ROOT) || (state_i == S_RD_LEAF);

  always_comb begin
    if (state_i == S_RD_ROOT) addr_o = {base_i, root_off};
    else                      addr_o = {frame_i, leaf_off};
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int IDX_W    = 10,
  parameter int PFN_W    = 20,
  parameter int DATA_W   = 32,
  parameter int ENTRY_LG = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             miss_valid_i,
  input  logic [VPN_W-1:0]                 miss_vpn_i,
  input  logic                             miss_is_data_i,
  input  logic [PFN_W-1:0]                 root_base_i,
  output logic                             busy_o,
  output logic                             done_o,
  output logic                             fault_o,
  output logic [VPN_W-1:0]                 fault_vpn_o,
  output logic                             mem_req_o,
  output logic [PFN_W+IDX_W+ENTRY_LG-1:0]  mem_addr_o,
  input  logic                             mem_rsp_valid_i,
  input  logic [DATA_W-1:0]                mem_rsp_data_i,
  output logic                             tlb_we_o,
  output logic [VPN_W-1:0]                 tlb_vpn_o,
  output logic [PFN_W-1:0]                 tlb_pfn_o,
  output logic                             tlb_is_data_o
);
  localparam int VALID_BIT = 0;

  walk_st_e          state;
  logic              pte_valid;
  logic [PFN_W-1:0]  pte_frame, base_q, frame_q;
  logic [VPN_W-1:0]  vpn_q;
  logic              is_data_q;

  assign pte_valid = mem_rsp_data_i[VALID_BIT];
  assign pte_frame = mem_rsp_data_i[DATA_W-1 -: PFN_W];

  ptw_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_valid_i (miss_valid_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .pte_valid_i  (pte_valid),
    .state_o      (state)
  );

  ptw_regs #(.VPN_W(VPN_W), .PFN_W(PFN_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .miss_valid_i (miss_valid_i),
    .vpn_i        (miss_vpn_i),
    .is_data_i    (miss_is_data_i),
    .base_i       (root_base_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .pte_frame_i  (pte_frame),
    .vpn_o        (vpn_q),
    .is_data_o    (is_data_q),
    .base_o       (base_q),
    .frame_o      (frame_q)
  );

  ptw_addr #(.VPN_W(VPN_W), .IDX_W(IDX_W), .PFN_W(PFN_W), .ENTRY_LG(ENTRY_LG)) i_addr (
    .state_i (state),
    .vpn_i   (vpn_q),
    .base_i  (base_q),
    .frame_i (frame_q),
    .req_o   (mem_req_o),
    .addr_o  (mem_addr_o)
  );

  assign busy_o        = (state != S_IDLE);
  assign tlb_we_o      = (state == S_FILL);
  assign done_o        = (state == S_FILL);
  assign fault_o       = (state == S_FAULT);
  assign fault_vpn_o   = vpn_q;
  assign tlb_vpn_o     = vpn_q;
  assign tlb_pfn_o     = frame_q;
  assign tlb_is_data_o = is_data_q;

  // R3
  first_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_req_o);
  // R5
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R6
  fill_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |-> $past(mem_rsp_valid_i) && $past(mem_rsp_data_i[VALID_BIT]));
  // R6
  fill_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |=> !tlb_we_o);
  // R7 R8
  fault_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(mem_rsp_valid_i) && !$past(mem_rsp_data_i[VALID_BIT]));
  // R9
  busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_we_o || fault_o) |=> !busy_o);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic [19:0] miss_vpn_i = '0;
  logic        miss_is_data_i = 1'b0;
  logic [19:0] root_base_i = '0;
  logic        busy_o, done_o, fault_o, mem_req_o, tlb_we_o, tlb_is_data_o;
  logic [19:0] fault_vpn_o, tlb_vpn_o, tlb_pfn_o;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  pt_walker i_pt_walker (.*);

  function automatic logic [19:0] frame_of(input logic [31:0] a);
    return a[21:2] ^ {a[31:22], a[31:22]} ^ 20'h9C3A5;
  endfunction

  // bits 11:1 carry junk to show they are ignored (R10)
  function automatic logic [31:0] pte_of(input logic [31:0] a, input logic v);
    return {frame_of(a), a[12:2] ^ 11'h6B3, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_walk(input logic [19:0] base, input logic [19:0] vpn, input logic isd,
                          input int lat, input logic bad_root, input logic bad_leaf,
                          input logic intrude);
    logic [31:0] exp_root, exp_leaf, got_root, got_leaf, cur;
    logic [19:0] exp_pfn;
    int reqs, cnt, rsp_cyc, hit_cyc;
    logic pend, hit;
    exp_root = {base, vpn[19:10], 2'b00};
    exp_leaf = {frame_of(exp_root), vpn[9:0], 2'b00};
    exp_pfn  = frame_of(exp_leaf);
    got_root = '0; got_leaf = '0; cur = '0;
    reqs = 0; cnt = 0; rsp_cyc = -10; hit_cyc = -1; pend = 0; hit = 0;
    @(negedge clk_i);
    root_base_i = base; miss_vpn_i = vpn; miss_is_data_i = isd; miss_valid_i = 1'b1;
    @(negedge clk_i);
    miss_valid_i = 1'b0; miss_vpn_i = ~vpn; root_base_i = ~base; miss_is_data_i = ~isd;
    chk("R9 busy after accept", 32'(busy_o), 32'd1);
    for (int cyc = 0; cyc < 100 && !hit; cyc++) begin
      if (tlb_we_o || fault_o) begin
        hit = 1; hit_cyc = cyc;
      end else begin
        mem_rsp_valid_i = 1'b0;
        if (mem_req_o) begin
          reqs++;
          if (reqs == 1) got_root = mem_addr_o; else got_leaf = mem_addr_o;
          cur = mem_addr_o; cnt = lat; pend = 1;
        end else if (pend) begin
          if (cnt == 0) begin
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = pte_of(cur, (reqs == 1) ? !bad_root : !bad_leaf);
            pend = 0; rsp_cyc = cyc;
          end else cnt--;
        end
        if (intrude) begin
          miss_valid_i = (cyc == 1);
          miss_vpn_i   = vpn ^ 20'h00421;
        end
        @(negedge clk_i);
      end
    end
    mem_rsp_valid_i = 1'b0; miss_valid_i = 1'b0;
    chk("R5 walk finished", 32'(hit), 32'd1);
    chk("R3 root address", got_root, exp_root);
    chk("R6 R7 R8 pulse one cycle after response", 32'(hit_cyc), 32'(rsp_cyc + 1));
    if (!bad_root && !bad_leaf) begin
      chk("R4 leaf address", got_leaf, exp_leaf);
      chk("R5 request count", 32'(reqs), 32'd2);
      chk("R6 write strobe", 32'(tlb_we_o), 32'd1);
      chk("R6 done", 32'(done_o), 32'd1);
      chk("R6 no fault", 32'(fault_o), 32'd0);
      chk("R2 R6 written vpn", 32'(tlb_vpn_o), 32'(vpn));
      chk("R6 R10 written pfn", 32'(tlb_pfn_o), 32'(exp_pfn));
      chk("R2 R6 select flag", 32'(tlb_is_data_o), 32'(isd));
    end else begin
      chk(bad_root ? "R7 request count" : "R8 request count", 32'(reqs), bad_root ? 32'd1 : 32'd2);
      if (!bad_root) chk("R4 leaf address", got_leaf, exp_leaf);
      chk(bad_root ? "R7 fault" : "R8 fault", 32'(fault_o), 32'd1);
      chk(bad_root ? "R7 no write" : "R8 no write", 32'(tlb_we_o | done_o), 32'd0);
      chk(bad_root ? "R7 fault vpn" : "R8 fault vpn", 32'(fault_vpn_o), 32'(vpn));
    end
    @(negedge clk_i);
    chk("R9 busy low after pulse", 32'(busy_o), 32'd0);
    chk("R6 pulse width", 32'(tlb_we_o | fault_o | done_o), 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", 32'({busy_o, done_o, fault_o, mem_req_o, tlb_we_o}), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle after reset", 32'({busy_o, done_o, fault_o, mem_req_o, tlb_we_o}), 32'd0);

    // stray responses while idle (R5)
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R5 stray response ignored", 32'({busy_o, mem_req_o, tlb_we_o, fault_o}), 32'd0);
    end
    mem_rsp_valid_i = 1'b0;

    // corner page numbers
    run_walk(20'h00000, 20'h00000, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    run_walk(20'hFFFFF, 20'hFFFFF, 1'b1, 1, 1'b0, 1'b0, 1'b0);
    run_walk(20'h12345, 20'h003FF, 1'b0, 3, 1'b0, 1'b0, 1'b0);
    run_walk(20'h54321, 20'hFFC00, 1'b1, 7, 1'b0, 1'b0, 1'b0);

    // sweep of page numbers, bases, latencies and intruding misses
    for (int i = 0; i < 48; i++) begin
      run_walk(20'hA0000 + 20'(i * 273), 20'(i * 12085 + i * i * 7), i[0], i % 6,
               1'b0, 1'b0, (i % 4) == 3);
    end

    // faults at both levels over several latencies
    for (int i = 0; i < 6; i++) begin
      run_walk(20'h0C0DE + 20'(i), 20'(i * 40961 + 5), i[0], i, 1'b1, 1'b0, i[1]);
      run_walk(20'h70F00 - 20'(i), 20'(i * 22229 + 9), !i[0], i, 1'b0, 1'b1, i[1]);
    end

    // back to normal after faults
    run_walk(20'h33333, 20'h5A5A5, 1'b1, 2, 1'b0, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule